// File: doc/BRIEF.md
# Partial-Width Register File with Merge-on-Write

This block holds sixteen 64-bit general-purpose registers that can be written and read at five widths: the low byte, the second byte (bits 15:8), the low half-word, the low word and the full register. A narrow write to the low byte, the second byte or the low half-word keeps every other bit of the register. A low-word write clears the upper 32 bits instead of keeping them. A full-width write replaces the whole register. The second byte can be addressed only in the first four registers. A second-byte write aimed at any other register is refused and raises a one-cycle error pulse.

One write port commits on the rising clock edge. Two independent read ports are combinational and return the selected slice right-aligned and zero-extended to 64 bits. A read never sees a write made in the same cycle. A synchronous reset clears the file. Both the write path and the read path use one width code: 3'b000 low byte, 3'b001 second byte, 3'b010 low half-word, 3'b011 low word, 3'b100 full register. Codes 3'b101 to 3'b111 are reserved.

Top module: `gpr_slice_file`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared to zero and `bad_access` is driven low.
- R2: A write with code 3'b000 sets bits 7:0 of the register to `wr_data[7:0]` and keeps bits 63:8.
- R3: A write with code 3'b001 to register 0 to 3 sets bits 15:8 to `wr_data[7:0]` and keeps bits 63:16 and 7:0.
- R4: A write with code 3'b010 sets bits 15:0 to `wr_data[15:0]` and keeps bits 63:16.
- R5: A write with code 3'b011 sets bits 31:0 to `wr_data[31:0]` and clears bits 63:32.
- R6: A write with code 3'b100 sets the whole register to `wr_data`.
- R7: A write with a reserved code (3'b101, 3'b110, 3'b111) changes no register and leaves `bad_access` low.
- R8: A write with code 3'b001 to register 4 to 15 changes no register. `bad_access` is high for exactly the cycle after that edge.
- R9: When `wr_en` is low at an edge, no register changes and `bad_access` is low in the following cycle.
- R10: Each read port returns its selected slice in the low bits with all higher bits zero. Code 3'b001 returns bits 15:8 in bits 7:0. Code 3'b001 on register 4 to 15, and any reserved code, returns zero.
- R11: A read of a register written in the same cycle returns the value from before that write.
- R12: The two read ports are independent and may address any registers and codes at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 4 | Register written |
| wr_sz | input | 3 | Width code of the write |
| wr_data | input | 64 | Write data, right-aligned |
| rd0_idx | input | 4 | Register read by port 0 |
| rd0_sz | input | 3 | Width code of port 0 |
| rd0_data | output | 64 | Port 0 slice, zero-extended |
| rd1_idx | input | 4 | Register read by port 1 |
| rd1_sz | input | 3 | Width code of port 1 |
| rd1_data | output | 64 | Port 1 slice, zero-extended |
| bad_access | output | 1 | One-cycle pulse after a refused second-byte write |

## Verification
A write and a read of the same register can fall in the same cycle. The read must then return the value held before the merge. The random phase often draws the same index for the write and for either read port. The bench checks each read before the edge, against a reference array that is updated only after the edge. A refused second-byte write can also coincide with a legal write in the next cycle. Back-to-back sequences check that the error pulse lasts exactly one cycle and that the refused register keeps its value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int unsigned WORD_W = 64;

    typedef logic [WORD_W-1:0] word_t;

    // Width/position code shared by write and read paths
    typedef enum logic [2:0] {
        SL_LO8 = 3'b000,
        SL_HI8 = 3'b001,
        SL_W16 = 3'b010,
        SL_W32 = 3'b011,
        SL_W64 = 3'b100
    } slice_e;

endpackage

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
    import gpr_pkg::*;
#(
    parameter int unsigned IDX_W          = 4,
    parameter int unsigned HIGH_BYTE_REGS = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       code,
    input  word_t            old_val,
    input  word_t            data,
    output word_t            new_val,
    output logic             accept,
    output logic             illegal
);

    localparam logic [IDX_W-1:0] HB_LIM = IDX_W'(HIGH_BYTE_REGS);

    logic hb_ok;

    assign hb_ok = (idx < HB_LIM);

    always_comb begin
        new_val = old_val;
        accept  = 1'b0;
        illegal = 1'b0;
        case (code)
            SL_LO8: begin
                new_val = {old_val[63:8], data[7:0]};
                accept  = 1'b1;
            end
            SL_HI8: begin
                if (hb_ok) begin
                    new_val = {old_val[63:16], data[7:0], old_val[7:0]};
                    accept  = 1'b1;
                end else begin
                    illegal = 1'b1;
                end
            end
            SL_W16: begin
                new_val = {old_val[63:16], data[15:0]};
                accept  = 1'b1;
            end
            SL_W32: begin
                new_val = {32'b0, data[31:0]};
                accept  = 1'b1;
            end
            SL_W64: begin
                new_val = data;
                accept  = 1'b1;
            end
            default: begin
                new_val = old_val;
            end
        endcase
    end

endmodule

// File: rtl/gpr_slice_read.sv
module gpr_slice_read
    import gpr_pkg::*;
#(
    parameter int unsigned IDX_W          = 4,
    parameter int unsigned HIGH_BYTE_REGS = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [2:0]       code,
    input  word_t            word,
    output word_t            slice
);

    localparam logic [IDX_W-1:0] HB_LIM = IDX_W'(HIGH_BYTE_REGS);

    always_comb begin
        slice = '0;
        case (code)
            SL_LO8: slice = {56'b0, word[7:0]};
            SL_HI8: slice = (idx < HB_LIM) ? {56'b0, word[15:8]} : '0;
            SL_W16: slice = {48'b0, word[15:0]};
            SL_W32: slice = {32'b0, word[31:0]};
            SL_W64: slice = word;
            default: slice = '0;
        endcase
    end

endmodule

// File: rtl/gpr_reg_bank.sv
module gpr_reg_bank
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_REGS-1:0] we_vec,
    input  word_t               din,
    output word_t               q [NUM_REGS]
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        word_t cell_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cell_q <= '0;
            end else if (we_vec[g]) begin
                cell_q <= din;
            end
        end

        assign q[g] = cell_q;
    end

endmodule

// File: rtl/gpr_slice_file.sv
module gpr_slice_file
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 16,
    parameter int unsigned HIGH_BYTE_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [2:0]       wr_sz,
    input  logic [63:0]      wr_data,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [2:0]       rd0_sz,
    output logic [63:0]      rd0_data,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [2:0]       rd1_sz,
    output logic [63:0]      rd1_data,
    output logic             bad_access
);

    localparam int unsigned NUM_RD = 2;

    word_t               regs_q [NUM_REGS];
    word_t               old_w;
    word_t               new_w;
    logic                accept;
    logic                illegal;
    logic [NUM_REGS-1:0] we_vec;

    logic [IDX_W-1:0]    rd_idx_v  [NUM_RD];
    logic [2:0]          rd_sz_v   [NUM_RD];
    word_t               rd_data_v [NUM_RD];

    assign old_w = regs_q[wr_idx];

    gpr_write_merge #(
        .IDX_W          (IDX_W),
        .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
    ) u_merge (
        .idx     (wr_idx),
        .code    (wr_sz),
        .old_val (old_w),
        .data    (wr_data),
        .new_val (new_w),
        .accept  (accept),
        .illegal (illegal)
    );

    always_comb begin
        we_vec = '0;
        if (wr_en && accept) begin
            we_vec[wr_idx] = 1'b1;
        end
    end

    gpr_reg_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we_vec (we_vec),
        .din    (new_w),
        .q      (regs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_access <= 1'b0;
        end else begin
            bad_access <= wr_en && illegal;
        end
    end

    assign rd_idx_v[0] = rd0_idx;
    assign rd_sz_v[0]  = rd0_sz;
    assign rd_idx_v[1] = rd1_idx;
    assign rd_sz_v[1]  = rd1_sz;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_slice_read #(
            .IDX_W          (IDX_W),
            .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
        ) u_rd (
            .idx   (rd_idx_v[p]),
            .code  (rd_sz_v[p]),
            .word  (regs_q[rd_idx_v[p]]),
            .slice (rd_data_v[p])
        );
    end

    assign rd0_data = rd_data_v[0];
    assign rd1_data = rd_data_v[1];

endmodule

// File: rtl/gpr_slice_file_chk.sv
module gpr_slice_file_chk
    import gpr_pkg::*;
#(
    parameter int unsigned NUM_REGS       = 16,
    parameter int unsigned HIGH_BYTE_REGS = 4,
    localparam int unsigned IDX_W         = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [2:0]       wr_sz,
    input logic [63:0]      wr_data,
    input logic [2:0]       rd0_sz,
    input logic [63:0]      rd0_data,
    input logic [2:0]       rd1_sz,
    input logic [63:0]      rd1_data,
    input logic             bad_access,
    input word_t            regs [NUM_REGS]
);

    localparam logic [IDX_W-1:0] HB_LIM = IDX_W'(HIGH_BYTE_REGS);

    word_t old_sel;
    logic  any_nz;
    logic  hb_bad;

    assign old_sel = regs[wr_idx];
    assign hb_bad  = wr_en && (wr_sz == 3'b001) && !(wr_idx < HB_LIM);

    always_comb begin
        any_nz = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            any_nz = any_nz | (|regs[i]);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!any_nz && !bad_access));

    // R2
    lo8_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 3'b000) |=>
        regs[$past(wr_idx)] == {$past(old_sel[63:8]), $past(wr_data[7:0])});

    // R3
    hi8_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 3'b001 && wr_idx < HB_LIM) |=>
        regs[$past(wr_idx)] == {$past(old_sel[63:16]), $past(wr_data[7:0]), $past(old_sel[7:0])});

    // R4
    w16_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 3'b010) |=>
        regs[$past(wr_idx)] == {$past(old_sel[63:16]), $past(wr_data[15:0])});

    // R5
    w32_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 3'b011) |=>
        regs[$past(wr_idx)] == {32'b0, $past(wr_data[31:0])});

    // R6
    w64_full_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz == 3'b100) |=> regs[$past(wr_idx)] == $past(wr_data));

    // R7
    reserved_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sz > 3'b100) |=>
        (regs[$past(wr_idx)] == $past(old_sel) && !bad_access));

    // R8
    hb_reject_chk: assert property (@(posedge clk) disable iff (rst)
        hb_bad |=> (bad_access && regs[$past(wr_idx)] == $past(old_sel)));

    // R8
    flag_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !hb_bad |=> !bad_access);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> regs[$past(wr_idx)] == $past(old_sel));

    // R10
    rd0_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_sz != 3'b011 && rd0_sz != 3'b100) |-> rd0_data[63:16] == 48'b0);

    // R12
    rd1_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd1_sz != 3'b011 && rd1_sz != 3'b100) |-> rd1_data[63:16] == 48'b0);

    // R10
    rd_byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (rd0_sz == 3'b000 || rd0_sz == 3'b001) |-> rd0_data[63:8] == 56'b0);

endmodule

bind gpr_slice_file gpr_slice_file_chk #(
    .NUM_REGS       (NUM_REGS),
    .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_sz      (wr_sz),
    .wr_data    (wr_data),
    .rd0_sz     (rd0_sz),
    .rd0_data   (rd0_data),
    .rd1_sz     (rd1_sz),
    .rd1_data   (rd1_data),
    .bad_access (bad_access),
    .regs       (regs_q)
);

// File: tb/gpr_slice_file_tb_top.sv
module gpr_slice_file_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_idx;
    logic [2:0]  wr_sz;
    logic [63:0] wr_data;
    logic [3:0]  rd0_idx;
    logic [2:0]  rd0_sz;
    logic [63:0] rd0_data;
    logic [3:0]  rd1_idx;
    logic [2:0]  rd1_sz;
    logic [63:0] rd1_data;
    logic        bad_access;

    logic [63:0] model [16];
    int          n_run  = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    gpr_slice_file dut_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_sz      (wr_sz),
        .wr_data    (wr_data),
        .rd0_idx    (rd0_idx),
        .rd0_sz     (rd0_sz),
        .rd0_data   (rd0_data),
        .rd1_idx    (rd1_idx),
        .rd1_sz     (rd1_sz),
        .rd1_data   (rd1_data),
        .bad_access (bad_access)
    );

    function automatic logic [63:0] exp_merge(logic [63:0] o, logic [63:0] d,
                                              logic [2:0] c, logic [3:0] i);
        case (c)
            3'd0: return {o[63:8], d[7:0]};
            3'd1: return (i < 4) ? {o[63:16], d[7:0], o[7:0]} : o;
            3'd2: return {o[63:16], d[15:0]};
            3'd3: return {32'b0, d[31:0]};
            3'd4: return d;
            default: return o;
        endcase
    endfunction

    function automatic logic [63:0] exp_slice(logic [63:0] v, logic [2:0] c, logic [3:0] i);
        case (c)
            3'd0: return {56'b0, v[7:0]};
            3'd1: return (i < 4) ? {56'b0, v[15:8]} : 64'b0;
            3'd2: return {48'b0, v[15:0]};
            3'd3: return {32'b0, v[31:0]};
            3'd4: return v;
            default: return 64'b0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(bit we, logic [3:0] wi, logic [2:0] ws, logic [63:0] wd,
                        logic [3:0] r0i, logic [2:0] r0s, logic [3:0] r1i, logic [2:0] r1s);
        bit ill;
        wr_en = we; wr_idx = wi; wr_sz = ws; wr_data = wd;
        rd0_idx = r0i; rd0_sz = r0s; rd1_idx = r1i; rd1_sz = r1s;
        #1;
        // R11 when the read hits the register being written, else R10
        check((we && r0i == wi) ? "R11" : "R10", rd0_data, exp_slice(model[r0i], r0s, r0i));
        check("R12", rd1_data, exp_slice(model[r1i], r1s, r1i));
        @(posedge clk);
        ill = we && (ws == 3'd1) && (wi >= 4);
        if (we) model[wi] = exp_merge(model[wi], wd, ws, wi);
        @(negedge clk);
        check(ill ? "R8" : (we ? "R7" : "R9"), {63'b0, bad_access}, {63'b0, ill});
    endtask

    task automatic verify_reg(string tag, logic [3:0] idx);
        wr_en = 1'b0;
        rd0_idx = idx; rd0_sz = 3'd4;
        #1;
        check(tag, rd0_data, model[idx]);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = 64'b0;
        check("R1", {63'b0, bad_access}, 64'b0);
        for (int i = 0; i < 16; i++) begin
            rd0_idx = i[3:0]; rd0_sz = 3'd4;
            #1;
            check("R1", rd0_data, 64'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1badcafe));
        rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_sz = '0; wr_data = '0;
        rd0_idx = '0; rd0_sz = '0; rd1_idx = '0; rd1_sz = '0;
        @(negedge clk);
        do_reset();

        // R6 full write
        step(1, 4'd0, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 3'd4, 4'd1, 3'd4);
        verify_reg("R6", 4'd0);
        // R2 low byte
        step(1, 4'd0, 3'd0, 64'h0000_0000_0000_005A, 4'd0, 3'd0, 4'd0, 3'd1);
        verify_reg("R2", 4'd0);
        // R3 second byte, register 3 is the last one allowed
        step(1, 4'd0, 3'd1, 64'h0000_0000_0000_00C3, 4'd0, 3'd1, 4'd0, 3'd2);
        verify_reg("R3", 4'd0);
        step(1, 4'd3, 3'd4, 64'h1122_3344_5566_7788, 4'd3, 3'd4, 4'd3, 3'd1);
        step(1, 4'd3, 3'd1, 64'hFFFF_FFFF_FFFF_FFA5, 4'd3, 3'd1, 4'd0, 3'd4);
        verify_reg("R3", 4'd3);
        // R4 half-word
        step(1, 4'd0, 3'd2, 64'h1234_5678_9ABC_BEEF, 4'd0, 3'd2, 4'd0, 3'd3);
        verify_reg("R4", 4'd0);
        // R5 low word clears upper half
        step(1, 4'd0, 3'd3, 64'hAAAA_AAAA_DEAD_BEEF, 4'd0, 3'd3, 4'd0, 3'd4);
        verify_reg("R5", 4'd0);
        // R7 reserved codes
        for (int c = 5; c < 8; c++) begin
            step(1, 4'd0, c[2:0], 64'h0123_4567_89AB_CDEF, 4'd0, c[2:0], 4'd0, 3'd4);
            verify_reg("R7", 4'd0);
        end
        // R8 refused second-byte writes, back to back, then legal
        step(1, 4'd4, 3'd4, 64'hCAFE_F00D_1234_5678, 4'd4, 3'd4, 4'd4, 3'd1);
        step(1, 4'd4, 3'd1, 64'h0000_0000_0000_0099, 4'd4, 3'd1, 4'd4, 3'd0);
        step(1, 4'd15, 3'd1, 64'h0000_0000_0000_0077, 4'd15, 3'd1, 4'd4, 3'd4);
        step(1, 4'd4, 3'd0, 64'h0000_0000_0000_0011, 4'd4, 3'd4, 4'd4, 3'd1);
        verify_reg("R8", 4'd4);
        // R9 write enable low
        step(0, 4'd4, 3'd4, 64'hFFFF_0000_FFFF_0000, 4'd4, 3'd4, 4'd0, 3'd0);
        verify_reg("R9", 4'd4);
        // R11 same-cycle read of written register
        step(1, 4'd2, 3'd4, 64'h5555_6666_7777_8888, 4'd2, 3'd4, 4'd2, 3'd3);
        step(1, 4'd2, 3'd0, 64'h0000_0000_0000_0001, 4'd2, 3'd4, 4'd2, 3'd0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] d;
            d = {$urandom(), $urandom()};
            step(($urandom() % 4) != 0, 4'($urandom()), 3'($urandom()), d,
                 4'($urandom()), 3'($urandom()), 4'($urandom()), 3'($urandom()));
        end

        // R1 reset after activity
        do_reset();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule